// File: doc/BRIEF.md
# Synchronous Burst SRAM with Flow-Through Read

This block is a single-port synchronous static memory meant to sit next to a processor or cache controller. Every control, address and write-data input is sampled on the rising clock edge. The read path has no output register: once an edge has latched an address, the stored word reaches the data output within the same cycle. Two asynchronous controls gate that output. One is an output enable. The other is a sleep input, which also stops the block from accepting any new work.

An access can be started by either of two address strobes. The controller strobe always acts when the chip enables are sampled. The processor strobe acts only when the block is selected, and its access is always a read. After a start, a two-bit burst generator steps through the four words of the aligned group. It moves only in cycles where advance is asserted. The order is linear or interleaved, chosen by a mode input that is captured when the burst starts.

Each word is split into byte lanes of nine bits: eight data bits plus a parity bit, which is stored like any other bit. A global write stores the whole word. A byte write stores only the selected lanes.

Top module: `sbs_sram_flow`

## Requirements
- R1: While reset is high and in the first cycle after it, the block is deselected and `dq_oe` is 0 with `dq_o` all zero.
- R2: A controller-strobe cycle with all enables valid (`en0_n`=0, `en1`=1, `en2_n`=0) loads `addr`. A read shows the stored word at that address on `dq_o` in the cycle that follows the same edge.
- R3: A controller-strobe cycle with any enable invalid deselects the block. After it the bus is not driven, and write controls have no effect until a new start.
- R4: A processor-strobe cycle with valid enables loads `addr` as a read even when write controls are active. When both strobes are active it takes priority over the controller strobe.
- R5: A processor strobe with any enable invalid is ignored: the current access, its address and its selection are unchanged.
- R6: With `burst_ilv`=0 captured at the start, each advance (`advance_n`=0) makes the low two address bits (start + n) mod 4. The upper bits do not change, and the fifth beat wraps back to the start address.
- R7: With `burst_ilv`=1 captured at the start, the low two address bits on beat n are start XOR n.
- R8: A cycle with no strobe and no advance keeps the current address.
- R9: `wr_all_n`=0 writes every lane, whatever `byte_sel_n` and `wr_byte_n` are.
- R10: With `wr_all_n`=1 and `wr_byte_n`=0, only lanes b with `byte_sel_n[b]`=0 are written. Lane b is bits [9b+8:9b], and bit 9b+8 is its parity. If no lane is selected, the cycle is a read.
- R11: `dq_oe` is 1 only when the block is selected, the cycle is a read, `oe_n`=0 and `sleep`=0. `oe_n` takes effect without a clock edge. `dq_o` is zero whenever `dq_oe` is 0.
- R12: While `sleep` is 1, the bus is released at once and clock edges start, advance and write nothing. When `sleep` falls, the stored data and the current address are still in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Word address sampled on a strobe |
| strobe_cpu_n | input | 1 | Processor start strobe, active low |
| strobe_ctl_n | input | 1 | Controller start strobe, active low |
| advance_n | input | 1 | Step the burst, active low |
| en0_n | input | 1 | Chip enable, active low |
| en1 | input | 1 | Chip enable, active high |
| en2_n | input | 1 | Chip enable, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| byte_sel_n | input | NB | Per-lane write select, active low |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep request |
| dq_i | input | NB*LW | Write data |
| dq_o | output | NB*LW | Read data, zero when not driven |
| dq_oe | output | 1 | High when the block drives the data bus |

## Verification
The assertions check properties that hold on every cycle. They cover the step from one burst address to the next in both orders, the fixed upper address bits across an advance, and the frozen state during sleep. They also check deselection after a strobe with an invalid enable, the read-only nature of processor-strobe cycles, and the released bus whenever output enable or sleep is inactive. Only the bench scenarios can show that data survives. That covers what a merged byte write leaves in the word, a global write that overrides the lane selects, writes that are lost while deselected or asleep, and the exact word returned when a burst wraps.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
package sbs_pkg;
  typedef enum logic [2:0] {
    CYC_HOLD,
    CYC_CTL,
    CYC_CPU,
    CYC_ADV,
    CYC_DESEL,
    CYC_SLEEP
  } cyc_e;

  // Low address bits for beat n of a four-word burst.
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] beat,
                                           input logic       ilv);
    return ilv ? (start ^ beat) : (start + beat);
  endfunction
endpackage

// File: rtl/sbs_cycle_dec.sv
`timescale 1ns/1ps
module sbs_cycle_dec
  import sbs_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic          strobe_cpu_n,
  input  logic          strobe_ctl_n,
  input  logic          advance_n,
  input  logic          en0_n,
  input  logic          en1,
  input  logic          en2_n,
  input  logic          sleep,
  input  logic          sel_q,
  input  logic          wr_all_n,
  input  logic          wr_byte_n,
  input  logic [NB-1:0] byte_sel_n,
  output cyc_e          cyc,
  output logic [NB-1:0] lane_mask
);
  logic ce_ok;
  assign ce_ok = !en0_n && en1 && !en2_n;

  // Priority: sleep, honoured processor strobe, controller strobe, advance.
  always_comb begin
    if (sleep)                          cyc = CYC_SLEEP;
    else if (!strobe_cpu_n && ce_ok)    cyc = CYC_CPU;
    else if (!strobe_ctl_n)             cyc = ce_ok ? CYC_CTL : CYC_DESEL;
    else if (sel_q && !advance_n)       cyc = CYC_ADV;
    else                                cyc = CYC_HOLD;
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign lane_mask[b] = !wr_all_n || (!wr_byte_n && !byte_sel_n[b]);
  end
endmodule

// File: rtl/sbs_burst_gen.sv
`timescale 1ns/1ps
module sbs_burst_gen
  import sbs_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  cyc_e          cyc,
  input  logic [AW-1:0] addr_in,
  input  logic          ilv_in,
  input  logic          lane_any,
  output logic          sel_q,
  output logic          wr_q,
  output logic          do_wr,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] nxt_addr
);
  localparam int UW = AW - 2;

  logic [UW-1:0] upper_q, upper_n;
  logic [1:0]    start_q, start_n, beat_q, beat_n;
  logic          ilv_q, ilv_n, sel_n;

  always_comb begin
    upper_n = upper_q;
    start_n = start_q;
    beat_n  = beat_q;
    ilv_n   = ilv_q;
    sel_n   = sel_q;
    case (cyc)
      CYC_CTL, CYC_CPU: begin
        upper_n = addr_in[AW-1:2];
        start_n = addr_in[1:0];
        beat_n  = 2'd0;
        ilv_n   = ilv_in;
        sel_n   = 1'b1;
      end
      CYC_ADV:   beat_n = beat_q + 2'd1;
      CYC_DESEL: sel_n  = 1'b0;
      default: ;
    endcase
    do_wr = sel_n && lane_any &&
            (cyc == CYC_CTL || cyc == CYC_ADV || cyc == CYC_HOLD);
  end

  assign nxt_addr = {upper_n, burst_low(start_n, beat_n, ilv_n)};
  assign cur_addr = {upper_q, burst_low(start_q, beat_q, ilv_q)};

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q <= '0;
      start_q <= 2'd0;
      beat_q  <= 2'd0;
      ilv_q   <= 1'b0;
      sel_q   <= 1'b0;
      wr_q    <= 1'b0;
    end else if (cyc != CYC_SLEEP) begin
      upper_q <= upper_n;
      start_q <= start_n;
      beat_q  <= beat_n;
      ilv_q   <= ilv_n;
      sel_q   <= sel_n;
      wr_q    <= do_wr;
    end
  end

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_ADV && !ilv_q) |=> cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1); // R6
  AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_ADV) |=> cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])); // R6
  AST_ILV_FLIP: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_ADV && ilv_q && beat_q[0]) |=> cur_addr[1:0] == ~$past(cur_addr[1:0])); // R7
  AST_DESEL_GONE: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_DESEL) |=> !sel_q); // R3
  AST_CPU_READ: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_CPU) |=> (sel_q && !wr_q)); // R4
  AST_SLEEP_KEEP: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_SLEEP) |=> ($stable(cur_addr) && $stable(sel_q))); // R12
endmodule

// File: rtl/sbs_lane_mem.sv
`timescale 1ns/1ps
module sbs_lane_mem #(
  parameter int AW = 8,
  parameter int NB = 4,
  parameter int LW = 9
) (
  input  logic           clk,
  input  logic [NB-1:0]  we,
  input  logic [AW-1:0]  waddr,
  input  logic [NB*LW-1:0] wdata,
  input  logic [AW-1:0]  raddr,
  output logic [NB*LW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[b]) mem[waddr] <= wdata[b*LW +: LW];
    end
    assign rdata[b*LW +: LW] = mem[raddr];
  end
endmodule

// File: rtl/sbs_sram_flow.sv
`timescale 1ns/1ps
module sbs_sram_flow
  import sbs_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 4,
  parameter int LW = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr,
  input  logic             strobe_cpu_n,
  input  logic             strobe_ctl_n,
  input  logic             advance_n,
  input  logic             en0_n,
  input  logic             en1,
  input  logic             en2_n,
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [NB-1:0]    byte_sel_n,
  input  logic             burst_ilv,
  input  logic             oe_n,
  input  logic             sleep,
  input  logic [NB*LW-1:0] dq_i,
  output logic [NB*LW-1:0] dq_o,
  output logic             dq_oe
);
  localparam int W = NB * LW;

  cyc_e          cyc;
  logic [NB-1:0] lane_mask, lane_we;
  logic          sel_q, wr_q, do_wr;
  logic [AW-1:0] cur_addr, nxt_addr;
  logic [W-1:0]  rdata;

  sbs_cycle_dec #(.NB(NB)) dec_i (
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
    .advance_n(advance_n), .en0_n(en0_n), .en1(en1), .en2_n(en2_n),
    .sleep(sleep), .sel_q(sel_q), .wr_all_n(wr_all_n),
    .wr_byte_n(wr_byte_n), .byte_sel_n(byte_sel_n),
    .cyc(cyc), .lane_mask(lane_mask)
  );

  sbs_burst_gen #(.AW(AW)) gen_i (
    .clk(clk), .rst(rst), .cyc(cyc), .addr_in(addr), .ilv_in(burst_ilv),
    .lane_any(|lane_mask), .sel_q(sel_q), .wr_q(wr_q), .do_wr(do_wr),
    .cur_addr(cur_addr), .nxt_addr(nxt_addr)
  );

  assign lane_we = do_wr ? lane_mask : '0;

  sbs_lane_mem #(.AW(AW), .NB(NB), .LW(LW)) mem_i (
    .clk(clk), .we(lane_we), .waddr(nxt_addr), .wdata(dq_i),
    .raddr(cur_addr), .rdata(rdata)
  );

  assign dq_oe = sel_q && !wr_q && !oe_n && !sleep;
  assign dq_o  = dq_oe ? rdata : '0;

  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (oe_n || sleep) |-> (!dq_oe && dq_o == '0)); // R11
endmodule

// File: tb/sbs_sram_flow_tb_top.sv
`timescale 1ns/1ps
module sbs_sram_flow_tb_top;
  localparam int AW = 8;
  localparam int NB = 4;
  localparam int LW = 9;
  localparam int W  = NB * LW;

  localparam logic [W-1:0] A0 = 36'h0_1111_1110;
  localparam logic [W-1:0] A1 = 36'h9_8765_4321;
  localparam logic [W-1:0] A2 = 36'hF_FFFF_FFFF;
  localparam logic [W-1:0] A3 = 36'h5_5AA5_5AA5;
  localparam logic [W-1:0] D9 = 36'h1_2345_6789;
  localparam logic [W-1:0] BM = 36'hF_F803_FE00; // lanes 1,3 kept, 0,2 cleared
  localparam logic [W-1:0] ZZ = '0;

  typedef struct packed {
    logic          cpu_n, ctl_n, adv_n, all_n, byt_n;
    logic [NB-1:0] bsel_n;
    logic          ce_ok, ilv;
    logic [AW-1:0] addr;
    logic [W-1:0]  din;
    logic          x_oe;
    logic [W-1:0]  x_dq;
    logic [23:0]   tag;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b1,1'b0,8'h10,A0,1'b0,ZZ,"R9"},  // global write burst
    '{1'b1,1'b1,1'b0,1'b0,1'b1,4'hF,1'b1,1'b0,8'h00,A1,1'b0,ZZ,"R6"},
    '{1'b1,1'b1,1'b0,1'b0,1'b1,4'hF,1'b1,1'b0,8'h00,A2,1'b0,ZZ,"R6"},
    '{1'b1,1'b1,1'b0,1'b0,1'b1,4'hF,1'b1,1'b0,8'h00,A3,1'b0,ZZ,"R6"},
    '{1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b1,1'b0,8'h12,ZZ,1'b1,A2,"R2"},  // flow-through read
    '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b1,1'b0,8'h00,ZZ,1'b1,A3,"R6"},
    '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b1,1'b0,8'h00,ZZ,1'b1,A0,"R6"},
    '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b1,1'b0,8'h00,ZZ,1'b1,A1,"R6"},
    '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b1,1'b0,8'h00,ZZ,1'b1,A2,"R6"},  // fifth beat wraps
    '{1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,1'b1,1'b0,8'h00,ZZ,1'b1,A2,"R8"},  // hold
    '{1'b0,1'b1,1'b1,1'b0,1'b1,4'h0,1'b1,1'b1,8'h11,ZZ,1'b1,A1,"R4"},  // cpu start ignores write
    '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b1,1'b1,8'h00,ZZ,1'b1,A0,"R7"},
    '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b1,1'b1,8'h00,ZZ,1'b1,A3,"R7"},
    '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b1,1'b1,8'h00,ZZ,1'b1,A2,"R7"},
    '{1'b1,1'b0,1'b1,1'b1,1'b0,4'hA,1'b1,1'b0,8'h12,ZZ,1'b0,ZZ,"R10"}, // lanes 0,2
    '{1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b1,1'b0,8'h12,ZZ,1'b1,BM,"R10"},
    '{1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b1,1'b0,8'h13,D9,1'b0,ZZ,"R9"},
    '{1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b1,1'b0,8'h13,ZZ,1'b1,D9,"R9"},
    '{1'b1,1'b0,1'b1,1'b1,1'b0,4'hF,1'b1,1'b0,8'h13,ZZ,1'b1,D9,"R10"}, // no lane -> read
    '{1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,1'b0,8'h13,ZZ,1'b0,ZZ,"R3"},
    '{1'b1,1'b1,1'b1,1'b0,1'b1,4'hF,1'b1,1'b0,8'h13,ZZ,1'b0,ZZ,"R3"},  // write while deselected
    '{1'b0,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,1'b0,8'h10,ZZ,1'b0,ZZ,"R5"},
    '{1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b1,1'b0,8'h13,ZZ,1'b1,D9,"R3"},
    '{1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b1,1'b0,8'h10,ZZ,1'b1,A0,"R2"},
    '{1'b0,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,1'b0,8'h12,ZZ,1'b1,A0,"R5"},
    '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b1,1'b0,8'h00,ZZ,1'b1,A1,"R5"},
    '{1'b0,1'b0,1'b1,1'b0,1'b1,4'hF,1'b1,1'b0,8'h11,ZZ,1'b1,A1,"R4"},  // cpu beats ctl
    '{1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b1,1'b0,8'h11,ZZ,1'b1,A1,"R4"}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic strobe_cpu_n = 1'b1, strobe_ctl_n = 1'b1, advance_n = 1'b1;
  logic en0_n = 1'b0, en1 = 1'b1, en2_n = 1'b0;
  logic wr_all_n = 1'b1, wr_byte_n = 1'b1;
  logic [NB-1:0] byte_sel_n = '1;
  logic burst_ilv = 1'b0, oe_n = 1'b0, sleep = 1'b0;
  logic [W-1:0] dq_i = '0;
  logic [W-1:0] dq_o;
  logic dq_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sbs_sram_flow #(.AW(AW), .NB(NB), .LW(LW)) dut_i (
    .clk(clk), .rst(rst), .addr(addr), .strobe_cpu_n(strobe_cpu_n),
    .strobe_ctl_n(strobe_ctl_n), .advance_n(advance_n), .en0_n(en0_n),
    .en1(en1), .en2_n(en2_n), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
    .byte_sel_n(byte_sel_n), .burst_ilv(burst_ilv), .oe_n(oe_n),
    .sleep(sleep), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  task automatic check(input string req, input logic x_oe, input logic [W-1:0] x_dq);
    n_chk++;
    if (dq_oe !== x_oe || dq_o !== x_dq) begin
      n_fail++;
      $display("FAIL %s: oe=%0b dq=%h expected oe=%0b dq=%h", req, dq_oe, dq_o, x_oe, x_dq);
    end
  endtask

  task automatic idle();
    strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b1; advance_n = 1'b1;
    wr_all_n = 1'b1; wr_byte_n = 1'b1; byte_sel_n = '1;
    en0_n = 1'b0; en1 = 1'b1; en2_n = 1'b0; dq_i = '0;
  endtask

  task automatic ctl_read(input logic [AW-1:0] a);
    @(negedge clk);
    idle();
    strobe_ctl_n = 1'b0; addr = a;
    @(posedge clk); #1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 in reset", 1'b0, ZZ);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1 check("R1 after reset", 1'b0, ZZ);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      strobe_cpu_n = TBL[i].cpu_n; strobe_ctl_n = TBL[i].ctl_n;
      advance_n = TBL[i].adv_n; wr_all_n = TBL[i].all_n;
      wr_byte_n = TBL[i].byt_n; byte_sel_n = TBL[i].bsel_n;
      en0_n = 1'b0; en1 = 1'b1; en2_n = !TBL[i].ce_ok;
      burst_ilv = TBL[i].ilv; addr = TBL[i].addr; dq_i = TBL[i].din;
      @(posedge clk); #1;
      check($sformatf("%s row %0d", TBL[i].tag, i), TBL[i].x_oe, TBL[i].x_dq);
    end

    // R3: each enable on its own deselects
    for (int k = 0; k < 3; k++) begin
      ctl_read(8'h13);
      check("R3 reselect", 1'b1, D9);
      @(negedge clk);
      idle();
      strobe_ctl_n = 1'b0; addr = 8'h13;
      en0_n = (k == 0); en1 = (k != 1); en2_n = (k == 2);
      @(posedge clk); #1 check($sformatf("R3 enable %0d", k), 1'b0, ZZ);
    end

    // R11: output enable acts without a clock edge
    ctl_read(8'h13);
    check("R11 driven", 1'b1, D9);
    oe_n = 1'b1; #0.5 check("R11 oe off", 1'b0, ZZ);
    oe_n = 1'b0; #0.5 check("R11 oe on", 1'b1, D9);

    // R12: sleep freezes state and blocks writes
    ctl_read(8'h10);
    check("R12 before sleep", 1'b1, A0);
    @(negedge clk);
    sleep = 1'b1; strobe_ctl_n = 1'b0; addr = 8'h13;
    advance_n = 1'b0; wr_all_n = 1'b0; dq_i = ZZ;
    #0.5 check("R12 bus released", 1'b0, ZZ);
    repeat (3) @(posedge clk);
    @(negedge clk);
    idle();
    sleep = 1'b0;
    #0.5 check("R12 address kept", 1'b1, A0);
    ctl_read(8'h13);
    check("R12 no write in sleep", 1'b1, D9);

    // R1: reset in the middle of an access
    @(negedge clk);
    idle();
    rst = 1'b1;
    @(posedge clk); #1 check("R1 mid reset", 1'b0, ZZ);
    @(negedge clk) rst = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end
endmodule